// File: doc/BRIEF.md
# Parallel flash command decoder

This block models, in synthesizable logic, the device side of a byte-wide parallel NOR flash. A host bus with address, write data, chip select, output enable and write enable (all active low) is sampled on the system clock. A write is taken on the clock where write enable is first seen high again while chip select is low. The decoder follows the unlock and command sequences written to two fixed unlock addresses and starts embedded byte-program and erase operations on an internal storage array. The array is split into equal sectors.

While an embedded operation runs, any enabled read returns a status byte instead of array data. Bit 7 of that byte is the inverse of bit 7 of the value being written. When the operation ends, reads return the true array contents. Program time and the sector-queue window are parameters counted in clock cycles. Erase walks the whole array once, one byte per cycle, and sets every byte of the selected sectors to FFh.

The sequencer states are: IDLE_READ, GOT_AA (first unlock write seen), GOT_55 (unlock pair complete), PROG_ARMED (program command seen), ERASE_1 (erase command seen), ERASE_2 (second unlock AAh), ERASE_3 (second unlock 55h), PROG_BUSY, ERASE_QUEUE (sector collection window) and ERASE_SWEEP. The transitions are:
- IDLE_READ→GOT_AA on AAh to the first unlock address.
- GOT_AA→GOT_55 on 55h to the second unlock address.
- GOT_55→PROG_ARMED on A0h, or GOT_55→ERASE_1 on 80h, both to the first unlock address.
- PROG_ARMED→PROG_BUSY on any write.
- ERASE_1→ERASE_2 on AAh to the first unlock address, then ERASE_2→ERASE_3 on 55h to the second unlock address.
- ERASE_3→ERASE_SWEEP on 10h to the first unlock address, which is chip erase.
- ERASE_3→ERASE_QUEUE on 30h to any address, which is sector erase.
- ERASE_QUEUE→ERASE_SWEEP when the window expires.
- PROG_BUSY→IDLE_READ and ERASE_SWEEP→IDLE_READ when the operation finishes.
- Any unexpected write in a sequence state goes back to IDLE_READ.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset every array byte reads FFh and the decoder is in IDLE_READ.
- R2: When chip select and output enable are both low and no operation runs, `bus_dout` equals the array byte at `bus_addr` and `bus_doe` is 1. When either of them is high, `bus_dout` is 00h and `bus_doe` is 0.
- R3: A write is accepted only in the clock cycle where `bus_we_n` is high, was low in the previous cycle, and `bus_cs_n` is low. Address and data are taken from that cycle. A write-enable pulse with chip select high has no effect.
- R4: A program takes four writes: AAh to U1, 55h to U2, A0h to U1, then the data to the target. U1 is 5555h and U2 is 2AAAh, each cut to its low min(15, ADDR_W) bits, and only those address bits are compared.
- R5: A program stores old AND data at the target. The result is readable PROG_CYC cycles after the accepted data write.
- R6: During an operation, an enabled read returns a status byte whose bit 7 is the inverse of bit 7 of the value being written and whose bits 6..0 are zero. Program uses the program data, so the status byte is 80h or 00h. Erase writes FFh, so the status byte is 00h.
- R7: Any write that does not match the next expected step of a sequence returns the decoder to IDLE_READ and leaves the array unchanged.
- R8: The erase sequence is AAh to U1, 55h to U2, 80h to U1, AAh to U1, 55h to U2, then 10h to U1. It sets every byte to FFh and the decoder is idle again 2^ADDR_W cycles after the final write.
- R9: When the erase sequence ends with 30h to any address, only that address's sector is set to FFh.
- R10: A further 30h write during the WIN_CYC-cycle window queues that write's sector and restarts the window. Other writes in the window are ignored. When the window expires, all queued sectors are erased together.
- R11: Writes accepted while a program runs, or during the erase sweep, are ignored.
- R12: The sector number is the top SECT_BITS address bits. With the defaults there are 8 sectors of 512 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_din | input | 8 | Write data |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_dout | output | 8 | Read data or status byte |
| bus_doe | output | 1 | Output drive enable |

## Verification
The assertions assume the bus is already synchronous to the clock. They also assume address and data are held steady in the cycle where write enable returns high. The bench meets this by changing inputs only just after a rising edge and by keeping each write three cycles long. An inline model of the sequence, the program timer, the sector queue and the sweep length predicts `bus_dout` and `bus_doe` at every falling edge. Directed reads cover the broken-sequence, ignored-write and queued-sector cases.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        IDLE_READ,
        GOT_AA,
        GOT_55,
        PROG_ARMED,
        ERASE_1,
        ERASE_2,
        ERASE_3,
        PROG_BUSY,
        ERASE_QUEUE,
        ERASE_SWEEP
    } fcmd_state_e;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] BYTE_BLANK  = 8'hFF;

    localparam logic [14:0] KEY_ADDR_A = 15'h5555;
    localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

endpackage

// File: rtl/fcmd_bus_sampler.sv
module fcmd_bus_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cs_n,
    input  logic bus_we_n,
    output logic wr_strobe
);

    logic we_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) we_seen <= 1'b1;
        else        we_seen <= bus_we_n;
    end

    assign wr_strobe = !we_seen && bus_we_n && !bus_cs_n;

    // R3: an accepted write can never repeat in the next cycle
    assert_one_cycle_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array #(
    parameter int ADDR_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [fcmd_pkg::DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]          rd_addr_a,
    output logic [fcmd_pkg::DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0]          rd_addr_b,
    output logic [fcmd_pkg::DATA_W-1:0] rd_data_b
);
    import fcmd_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= BYTE_BLANK;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data_a = cells[rd_addr_a];
    assign rd_data_b = cells[rd_addr_b];

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq #(
    parameter int ADDR_W    = 12,
    parameter int SECT_BITS = 3,
    parameter int PROG_CYC  = 6,
    parameter int WIN_CYC   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_strobe,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [fcmd_pkg::DATA_W-1:0] wr_data,
    input  logic [fcmd_pkg::DATA_W-1:0] prog_old,
    output logic [ADDR_W-1:0]           prog_addr,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_waddr,
    output logic [fcmd_pkg::DATA_W-1:0] mem_wdata,
    output logic                        busy,
    output logic [fcmd_pkg::DATA_W-1:0] status
);
    import fcmd_pkg::*;

    localparam int CMP_W   = (ADDR_W < 15) ? ADDR_W : 15;
    localparam int NSECT   = 1 << SECT_BITS;
    localparam int CNT_MAX = (PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0]  PROG_LAST  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0]  WIN_LAST   = CNT_W'(WIN_CYC - 1);
    localparam logic [ADDR_W-1:0] SWEEP_LAST = '1;

    fcmd_state_e        st, st_n;
    logic [ADDR_W-1:0]  pa, pa_n;
    logic [DATA_W-1:0]  pd, pd_n;
    logic [CNT_W-1:0]   cnt, cnt_n;
    logic [ADDR_W-1:0]  idx, idx_n;
    logic [NSECT-1:0]   mask, mask_n;

    logic               hit_a, hit_b;
    logic [NSECT-1:0]   sect_hot;

    assign hit_a    = wr_addr[CMP_W-1:0] == KEY_ADDR_A[CMP_W-1:0];
    assign hit_b    = wr_addr[CMP_W-1:0] == KEY_ADDR_B[CMP_W-1:0];
    assign sect_hot = {{(NSECT-1){1'b0}}, 1'b1} << wr_addr[ADDR_W-1 -: SECT_BITS];

    // next state and datapath
    always_comb begin
        st_n   = st;
        pa_n   = pa;
        pd_n   = pd;
        cnt_n  = cnt;
        idx_n  = idx;
        mask_n = mask;
        unique case (st)
            IDLE_READ: begin
                if (wr_strobe && hit_a && wr_data == CMD_KEY_A) st_n = GOT_AA;
            end
            GOT_AA: begin
                if (wr_strobe) st_n = (hit_b && wr_data == CMD_KEY_B) ? GOT_55 : IDLE_READ;
            end
            GOT_55: begin
                if (wr_strobe) begin
                    if (hit_a && wr_data == CMD_PROGRAM)    st_n = PROG_ARMED;
                    else if (hit_a && wr_data == CMD_ERASE) st_n = ERASE_1;
                    else                                    st_n = IDLE_READ;
                end
            end
            PROG_ARMED: begin
                if (wr_strobe) begin
                    st_n  = PROG_BUSY;
                    pa_n  = wr_addr;
                    pd_n  = wr_data;
                    cnt_n = '0;
                end
            end
            ERASE_1: begin
                if (wr_strobe) st_n = (hit_a && wr_data == CMD_KEY_A) ? ERASE_2 : IDLE_READ;
            end
            ERASE_2: begin
                if (wr_strobe) st_n = (hit_b && wr_data == CMD_KEY_B) ? ERASE_3 : IDLE_READ;
            end
            ERASE_3: begin
                if (wr_strobe) begin
                    if (hit_a && wr_data == CMD_CHIP) begin
                        st_n   = ERASE_SWEEP;
                        mask_n = '1;
                        idx_n  = '0;
                        pd_n   = BYTE_BLANK;
                    end else if (wr_data == CMD_SECTOR) begin
                        st_n   = ERASE_QUEUE;
                        mask_n = sect_hot;
                        cnt_n  = '0;
                        pd_n   = BYTE_BLANK;
                    end else begin
                        st_n   = IDLE_READ;
                    end
                end
            end
            PROG_BUSY: begin
                if (cnt == PROG_LAST) st_n = IDLE_READ;
                else                  cnt_n = cnt + 1'b1;
            end
            ERASE_QUEUE: begin
                if (wr_strobe && wr_data == CMD_SECTOR) begin
                    mask_n = mask | sect_hot;
                    cnt_n  = '0;
                end else if (cnt == WIN_LAST) begin
                    st_n  = ERASE_SWEEP;
                    idx_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ERASE_SWEEP: begin
                if (idx == SWEEP_LAST) begin
                    st_n   = IDLE_READ;
                    mask_n = '0;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= IDLE_READ;
            pa   <= '0;
            pd   <= BYTE_BLANK;
            cnt  <= '0;
            idx  <= '0;
            mask <= '0;
        end else begin
            st   <= st_n;
            pa   <= pa_n;
            pd   <= pd_n;
            cnt  <= cnt_n;
            idx  <= idx_n;
            mask <= mask_n;
        end
    end

    // outputs
    always_comb begin
        prog_addr = pa;
        busy      = (st == PROG_BUSY) || (st == ERASE_QUEUE) || (st == ERASE_SWEEP);
        status    = {~pd[DATA_W-1], {(DATA_W-1){1'b0}}};
        if (st == ERASE_SWEEP) begin
            mem_we    = mask[idx[ADDR_W-1 -: SECT_BITS]];
            mem_waddr = idx;
            mem_wdata = BYTE_BLANK;
        end else begin
            mem_we    = (st == PROG_BUSY) && (cnt == PROG_LAST);
            mem_waddr = pa;
            mem_wdata = prog_old & pd;
        end
    end

    assert_prog_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PROG_BUSY) |-> (cnt <= PROG_LAST));

    assert_window_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ERASE_QUEUE) |-> (cnt <= WIN_LAST && mask != '0));

    assert_sweep_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ERASE_SWEEP && $past(st) == ERASE_SWEEP) |-> (idx == $past(idx) + 1'b1));

    assert_target_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PROG_BUSY && $past(st) == PROG_BUSY) |-> ($stable(pa) && $stable(pd)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W    = 12,
    parameter int SECT_BITS = 3,
    parameter int PROG_CYC  = 6,
    parameter int WIN_CYC   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    input  logic              bus_cs_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    output logic [7:0]        bus_dout,
    output logic              bus_doe
);
    import fcmd_pkg::*;

    logic              wr_strobe;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_old;
    logic [DATA_W-1:0] rd_byte;
    logic              busy;
    logic [DATA_W-1:0] status;
    logic              rd_en;

    fcmd_bus_sampler i_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs_n  (bus_cs_n),
        .bus_we_n  (bus_we_n),
        .wr_strobe (wr_strobe)
    );

    fcmd_seq #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS),
        .PROG_CYC  (PROG_CYC),
        .WIN_CYC   (WIN_CYC)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .wr_addr   (bus_addr),
        .wr_data   (bus_din),
        .prog_old  (prog_old),
        .prog_addr (prog_addr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .status    (status)
    );

    fcmd_array #(
        .ADDR_W (ADDR_W)
    ) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mem_we),
        .wr_addr   (mem_waddr),
        .wr_data   (mem_wdata),
        .rd_addr_a (bus_addr),
        .rd_data_a (rd_byte),
        .rd_addr_b (prog_addr),
        .rd_data_b (prog_old)
    );

    assign rd_en    = !bus_cs_n && !bus_oe_n;
    assign bus_doe  = rd_en;
    assign bus_dout = !rd_en ? 8'h00 : (busy ? status : rd_byte);

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int ADDR_W    = 12;
    localparam int SECT_BITS = 3;
    localparam int PROG_CYC  = 6;
    localparam int WIN_CYC   = 16;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SSHIFT    = ADDR_W - SECT_BITS;
    localparam logic [ADDR_W-1:0] U1 = 12'h555;
    localparam logic [ADDR_W-1:0] U2 = 12'hAAA;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_din = '0;
    logic              bus_cs_n = 1'b1;
    logic              bus_oe_n = 1'b1;
    logic              bus_we_n = 1'b1;
    logic [7:0]        bus_dout;
    logic              bus_doe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC)
    ) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_din(bus_din),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_dout(bus_dout), .bus_doe(bus_doe)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] ref_mem [DEPTH];
    int  mstep;          // position in the command sequence
    int  mbusy;          // 0 none, 1 program, 2 queue window, 3 sweep
    int  prog_left, win_left, sweep_left;
    logic [ADDR_W-1:0] mpa;
    logic [7:0] mpd;
    bit  chip;
    int  pend[$];
    logic prev_we;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
            mstep = 0; mbusy = 0; prev_we = 1'b1; chip = 0; mpd = 8'hFF;
            pend.delete();
        end else begin
            bit wr;
            wr = !prev_we && bus_we_n && !bus_cs_n;
            prev_we = bus_we_n;
            if (mbusy == 1) begin
                prog_left--;
                if (prog_left == 0) begin
                    ref_mem[mpa] = ref_mem[mpa] & mpd;
                    mbusy = 0;
                end
            end else if (mbusy == 2) begin
                if (wr && bus_din == 8'h30) begin
                    pend.push_back(int'(bus_addr) >> SSHIFT);
                    win_left = WIN_CYC;
                end else begin
                    win_left--;
                    if (win_left == 0) begin
                        mbusy = 3;
                        sweep_left = DEPTH;
                    end
                end
            end else if (mbusy == 3) begin
                sweep_left--;
                if (sweep_left == 0) begin
                    for (int i = 0; i < DEPTH; i++)
                        if (chip || ((i >> SSHIFT) inside {pend})) ref_mem[i] = 8'hFF;
                    pend.delete();
                    chip = 0;
                    mbusy = 0;
                end
            end else if (wr) begin
                case (mstep)
                    0: if (bus_addr == U1 && bus_din == 8'hAA) mstep = 1;
                    1: mstep = (bus_addr == U2 && bus_din == 8'h55) ? 2 : 0;
                    2: if (bus_addr == U1 && bus_din == 8'hA0) mstep = 3;
                       else if (bus_addr == U1 && bus_din == 8'h80) mstep = 4;
                       else mstep = 0;
                    3: begin
                        mbusy = 1; prog_left = PROG_CYC;
                        mpa = bus_addr; mpd = bus_din; mstep = 0;
                    end
                    4: mstep = (bus_addr == U1 && bus_din == 8'hAA) ? 5 : 0;
                    5: mstep = (bus_addr == U2 && bus_din == 8'h55) ? 6 : 0;
                    default: begin
                        mstep = 0;
                        if (bus_addr == U1 && bus_din == 8'h10) begin
                            chip = 1; mbusy = 3; sweep_left = DEPTH; mpd = 8'hFF;
                        end else if (bus_din == 8'h30) begin
                            pend.push_back(int'(bus_addr) >> SSHIFT);
                            mbusy = 2; win_left = WIN_CYC; mpd = 8'hFF;
                        end
                    end
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] exp_d;
            logic       exp_e;
            exp_e = !bus_cs_n && !bus_oe_n;
            if (!exp_e)          exp_d = 8'h00;
            else if (mbusy != 0) exp_d = {~mpd[7], 7'b0};
            else                 exp_d = ref_mem[bus_addr];
            n_chk++;
            if (bus_dout !== exp_d || bus_doe !== exp_e) begin
                n_bad++;
                $display("FAIL %s per-cycle model: dout=%h doe=%b expected dout=%h doe=%b",
                         (mbusy != 0) ? "R6" : "R2", bus_dout, bus_doe, exp_d, exp_e);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_din = d; bus_cs_n = 1'b0; bus_we_n = 1'b0;
        @(posedge clk); #1;
        bus_we_n = 1'b1;
        @(posedge clk); #1;
        bus_cs_n = 1'b1;
    endtask

    task automatic pulse_no_cs(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_din = d; bus_cs_n = 1'b1; bus_we_n = 1'b0;
        @(posedge clk); #1;
        bus_we_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_cs_n = 1'b0; bus_oe_n = 1'b0;
        @(negedge clk);
        n_chk++;
        if (bus_dout !== exp || bus_doe !== 1'b1) begin
            n_bad++;
            $display("FAIL %s read %h: got %h doe=%b expected %h doe=1", tag, a, bus_dout, bus_doe, exp);
        end
        @(posedge clk); #1;
        bus_cs_n = 1'b1; bus_oe_n = 1'b1;
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr(U1, 8'hAA); wr(U2, 8'h55); wr(U1, 8'hA0); wr(a, d);
    endtask

    task automatic erase_head();
        wr(U1, 8'hAA); wr(U2, 8'h55); wr(U1, 8'h80); wr(U1, 8'hAA); wr(U2, 8'h55);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1: erased after reset
        rd(12'h000, 8'hFF, "R1");
        rd(12'hFFF, 8'hFF, "R1");

        // R2: output off when chip select high
        bus_oe_n = 1'b0; bus_cs_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (bus_dout !== 8'h00 || bus_doe !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 idle bus: got %h doe=%b expected 00 doe=0", bus_dout, bus_doe);
        end
        tick(1); bus_oe_n = 1'b1;

        // R4, R6, R5: program then status then data
        prog(12'h010, 8'h3C);
        rd(12'h010, 8'h80, "R6");
        tick(10);
        rd(12'h010, 8'h3C, "R4");
        prog(12'h010, 8'hF0);
        rd(12'h123, 8'h00, "R6");
        tick(10);
        rd(12'h010, 8'h30, "R5");

        // R7: broken sequences
        wr(U1, 8'hAA); wr(U2, 8'h55); wr(U1, 8'h77); wr(12'h020, 8'h12);
        tick(10);
        rd(12'h020, 8'hFF, "R7");
        wr(U1, 8'hAA); wr(12'h123, 8'h55); wr(U1, 8'hA0); wr(12'h030, 8'h00);
        tick(10);
        rd(12'h030, 8'hFF, "R7");

        // R3: write pulse with chip select high is not taken
        wr(U1, 8'hAA); wr(U2, 8'h55); wr(U1, 8'hA0);
        pulse_no_cs(12'h040, 8'h00);
        wr(12'h040, 8'h0F);
        tick(10);
        rd(12'h040, 8'h0F, "R3");

        // R11: write during program busy ignored
        prog(12'h050, 8'h0F);
        wr(U1, 8'hAA);
        tick(10);
        wr(U2, 8'h55); wr(U1, 8'hA0); wr(12'h060, 8'h00);
        tick(10);
        rd(12'h060, 8'hFF, "R11");
        rd(12'h050, 8'h0F, "R5");

        // R9, R12: single-sector erase, plus write during sweep ignored (R11)
        prog(12'h200, 8'h00); tick(10);
        prog(12'h400, 8'h00); tick(10);
        erase_head();
        wr(12'h2AB, 8'h30);
        rd(12'h2AB, 8'h00, "R6");
        tick(40);
        wr(12'h400, 8'h30);
        tick(4200);
        rd(12'h200, 8'hFF, "R9");
        rd(12'h3FF, 8'hFF, "R12");
        rd(12'h400, 8'h00, "R11");
        rd(12'h010, 8'h30, "R9");

        // R10: queued sectors
        prog(12'h600, 8'h11); tick(10);
        prog(12'hA00, 8'h22); tick(10);
        prog(12'hE00, 8'h33); tick(10);
        erase_head();
        wr(12'h600, 8'h30);
        wr(12'hE00, 8'h30);
        wr(12'hA00, 8'h55);
        tick(4200);
        rd(12'h600, 8'hFF, "R10");
        rd(12'hE00, 8'hFF, "R10");
        rd(12'hA00, 8'h22, "R10");
        rd(12'h400, 8'h00, "R10");

        // R8: chip erase
        erase_head();
        wr(U1, 8'h10);
        rd(12'h777, 8'h00, "R6");
        tick(4200);
        rd(12'h010, 8'hFF, "R8");
        rd(12'h400, 8'hFF, "R8");
        rd(12'hA00, 8'hFF, "R8");
        rd(12'h050, 8'hFF, "R8");

        tick(4);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule